// File: doc/BRIEF.md
# SuperSpeed Port Compliance-Mode Entry Controller

This block decides when each port of a SuperSpeed hub drops into Compliance Mode, the transmitter test state. Port 0 is the upstream port and ports 1 to N_DS are downstream. Every port has a watchdog on its polling phase. The watchdog measures a polling timeout, 360 ms by default, through a 1 ms prescaler derived from the clock frequency parameter. It advances only while the far-end receiver terminations are present and polling has not yet succeeded. An expired watchdog may push the port into Compliance Mode, but only if that port has never polled successfully since power-on.

Downstream ports have two further gates. They need a live upstream SuperSpeed link at the moment of entry. They also have an entry source that the hub configuration selects. In timeout mode the entry can be switched off by an enable bit. In command mode only a host request naming the port counts, and timeouts are ignored.

Once a port is in Compliance Mode, every ping LFPS on its receive side steps a pattern index. The index wraps after the last pattern, and the block emits a one-cycle advance pulse. A port leaves Compliance Mode only on power-on reset or on its own port reset.

Top module: `cmpl_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and for the first two clock edges after it rises, every `cmpl_active` and `pat_adv` bit is 0 and every pattern index is 0.
- R2: Port 0 raises `cmpl_active[0]` on the edge after its watchdog has counted TIMEOUT_MS*CLK_HZ/1000 qualifying cycles. A qualifying cycle is one with `poll_active`=1, `rx_term`=1 and `poll_ok`=0.
- R3: The watchdog holds its count while `poll_active`=1 but the cycle is not qualifying. It restarts from zero on any cycle with `poll_active`=0 or with the port's `port_rst`=1.
- R4: One cycle with `poll_ok`=1 on a port blocks timeout entry for that port until the next `rst_n` low. `port_rst` does not lift the block.
- R5: A downstream port enters on timeout only if all of the following hold in the cycle the watchdog is expired: `ds_cmd_mode`=0, `ds_to_en`=1, `us_link_ok`=1, and the port has never polled.
- R6: With `ds_cmd_mode`=1, downstream port i enters on the edge after a cycle with `cmd_valid`=1, `cmd_port`=i (binary port number) and `us_link_ok`=1. Timeouts on downstream ports are ignored in this mode. A command naming port 0 has no effect.
- R7: Losing `us_link_ok` after a downstream port has entered does not clear its `cmpl_active`.
- R8: `cmpl_active[i]` falls only through `rst_n` or `port_rst[i]`. `port_rst[i]` also clears the pattern index and wins over a simultaneous entry.
- R9: A cycle with `lfps_ping[i]`=1 while `cmpl_active[i]`=1 and `port_rst[i]`=0 produces `pat_adv[i]`=1 on the next edge, together with an index step. A ping outside Compliance Mode changes nothing.
- R10: Port i's pattern index sits at `pat_idx[i*PAT_W +: PAT_W]` and counts 0 to N_PAT-1. After N_PAT-1 it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| port_rst | input | N_DS+1 | Per-port reset, synchronous |
| rx_term | input | N_DS+1 | Far-end receiver terminations detected |
| poll_active | input | N_DS+1 | Port is in its polling phase |
| poll_ok | input | N_DS+1 | Polling completed successfully |
| us_link_ok | input | 1 | Upstream SuperSpeed link is valid |
| ds_to_en | input | 1 | Allows timeout entry on downstream ports |
| ds_cmd_mode | input | 1 | 1 selects command-only entry for downstream ports |
| cmd_valid | input | 1 | Host compliance request strobe |
| cmd_port | input | clog2(N_DS+1) | Port number named by the request |
| lfps_ping | input | N_DS+1 | Ping LFPS received |
| cmpl_active | output | N_DS+1 | Port is in Compliance Mode |
| pat_adv | output | N_DS+1 | One-cycle pattern-advance pulse |
| pat_idx | output | (N_DS+1)*PAT_W | Current pattern index per port |

## Verification
The bench builds the block with N_DS=3, CLK_HZ=4000 and TIMEOUT_MS=5, so the prescaler divides by 4 and a timeout takes 20 qualifying cycles. That short timeout lets the bench reach saturation, the hold-and-restart behaviour and late gate changes within a few dozen cycles. N_PAT=5 is deliberately not a power of two, so the wrap to zero is an explicit compare rather than natural overflow. Four ports cover the upstream port, a downstream port fed by each entry source, and a port that has already polled.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

  typedef enum logic {
    PORT_UP   = 1'b0,
    PORT_DOWN = 1'b1
  } port_kind_e;

  localparam int unsigned MS_PER_S = 1000;

endpackage

// File: rtl/cmpl_poll_timer.sv
module cmpl_poll_timer #(
  parameter int unsigned PRE_DIV    = 250000,
  parameter int unsigned TIMEOUT_MS = 360
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr,
  input  logic cnt_en,
  output logic expired
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int unsigned MS_W  = $clog2(TIMEOUT_MS + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             pre_wrap;

  assign expired  = (ms_q == MS_W'(TIMEOUT_MS));
  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (clr) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (cnt_en && !expired) begin
      if (pre_wrap) begin
        pre_d = '0;
        ms_d  = ms_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

endmodule

// File: rtl/cmpl_port_ctl.sv
module cmpl_port_ctl #(
  parameter cmpl_pkg::port_kind_e KIND = cmpl_pkg::PORT_DOWN
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic port_rst,
  input  logic poll_ok,
  input  logic expired,
  input  logic us_link_ok,
  input  logic ds_to_en,
  input  logic ds_cmd_mode,
  input  logic cmd_hit,
  output logic active
);
  logic never_q, never_d;
  logic act_q, act_d;
  logic enter;

  generate
    if (KIND == cmpl_pkg::PORT_UP) begin : g_up
      logic unused_ds;
      assign unused_ds = us_link_ok ^ ds_to_en ^ ds_cmd_mode ^ cmd_hit;
      assign enter = expired && never_q;
    end else begin : g_down
      logic to_path;
      assign to_path = ds_to_en && expired && never_q;
      assign enter   = us_link_ok && (ds_cmd_mode ? cmd_hit : to_path);
    end
  endgenerate

  always_comb begin
    never_d = never_q && !poll_ok;
    if (port_rst) begin
      act_d = 1'b0;
    end else begin
      act_d = act_q || enter;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      never_q <= 1'b1;
      act_q   <= 1'b0;
    end else begin
      never_q <= never_d;
      act_q   <= act_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/cmpl_pattern_step.sv
module cmpl_pattern_step #(
  parameter int unsigned N_PAT = 9,
  parameter int unsigned PAT_W = $clog2(N_PAT)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             port_rst,
  input  logic             active,
  input  logic             ping,
  output logic             adv,
  output logic [PAT_W-1:0] idx
);
  logic [PAT_W-1:0] idx_q, idx_d;
  logic             adv_q, adv_d;
  logic             step;

  assign step = active && ping && !port_rst;

  always_comb begin
    adv_d = step;
    idx_d = idx_q;
    if (port_rst) begin
      idx_d = '0;
    end else if (step) begin
      if (idx_q == PAT_W'(N_PAT - 1)) idx_d = '0;
      else                            idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      adv_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      adv_q <= adv_d;
    end
  end

  assign adv = adv_q;
  assign idx = idx_q;

endmodule

// File: rtl/cmpl_entry_ctrl.sv
module cmpl_entry_ctrl #(
  parameter int unsigned N_DS       = 3,
  parameter int unsigned CLK_HZ     = 250000000,
  parameter int unsigned TIMEOUT_MS = 360,
  parameter int unsigned N_PAT      = 9,
  localparam int unsigned NP        = N_DS + 1,
  localparam int unsigned PORT_W    = (NP > 1) ? $clog2(NP) : 1,
  localparam int unsigned PAT_W     = $clog2(N_PAT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NP-1:0]       port_rst,
  input  logic [NP-1:0]       rx_term,
  input  logic [NP-1:0]       poll_active,
  input  logic [NP-1:0]       poll_ok,
  input  logic                us_link_ok,
  input  logic                ds_to_en,
  input  logic                ds_cmd_mode,
  input  logic                cmd_valid,
  input  logic [PORT_W-1:0]   cmd_port,
  input  logic [NP-1:0]       lfps_ping,
  output logic [NP-1:0]       cmpl_active,
  output logic [NP-1:0]       pat_adv,
  output logic [NP*PAT_W-1:0] pat_idx
);
  import cmpl_pkg::*;

  localparam int unsigned PRE_DIV = CLK_HZ / MS_PER_S;

  logic rst_s1, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic [NP-1:0] expired;
  logic [NP-1:0] tmr_clr;
  logic [NP-1:0] tmr_en;
  logic [NP-1:0] cmd_hit;

  generate
    for (genvar i = 0; i < NP; i++) begin : g_port
      assign tmr_clr[i] = !poll_active[i] || port_rst[i];
      assign tmr_en[i]  = rx_term[i] && !poll_ok[i];
      assign cmd_hit[i] = cmd_valid && (cmd_port == PORT_W'(i));

      cmpl_poll_timer #(
        .PRE_DIV   (PRE_DIV),
        .TIMEOUT_MS(TIMEOUT_MS)
      ) u_tmr (
        .clk    (clk),
        .rst_ni (rst_sync_n),
        .clr    (tmr_clr[i]),
        .cnt_en (tmr_en[i]),
        .expired(expired[i])
      );

      cmpl_port_ctl #(
        .KIND((i == 0) ? PORT_UP : PORT_DOWN)
      ) u_ctl (
        .clk        (clk),
        .rst_ni     (rst_sync_n),
        .port_rst   (port_rst[i]),
        .poll_ok    (poll_ok[i]),
        .expired    (expired[i]),
        .us_link_ok (us_link_ok),
        .ds_to_en   (ds_to_en),
        .ds_cmd_mode(ds_cmd_mode),
        .cmd_hit    (cmd_hit[i]),
        .active     (cmpl_active[i])
      );

      cmpl_pattern_step #(
        .N_PAT(N_PAT),
        .PAT_W(PAT_W)
      ) u_pat (
        .clk     (clk),
        .rst_ni  (rst_sync_n),
        .port_rst(port_rst[i]),
        .active  (cmpl_active[i]),
        .ping    (lfps_ping[i]),
        .adv     (pat_adv[i]),
        .idx     (pat_idx[i*PAT_W +: PAT_W])
      );
    end
  endgenerate

endmodule

// File: rtl/cmpl_entry_chk.sv
module cmpl_entry_chk #(
  parameter int unsigned NP    = 4,
  parameter int unsigned N_PAT = 9,
  parameter int unsigned PAT_W = 4
) (
  input logic                clk,
  input logic                rst_ni,
  input logic [NP-1:0]       port_rst,
  input logic [NP-1:0]       lfps_ping,
  input logic                us_link_ok,
  input logic [NP-1:0]       cmpl_active,
  input logic [NP-1:0]       pat_adv,
  input logic [NP*PAT_W-1:0] pat_idx
);

  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_ni |-> (cmpl_active == '0 && pat_adv == '0 && pat_idx == '0));

  generate
    for (genvar i = 0; i < NP; i++) begin : g_chk
      p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_ni)
        (cmpl_active[i] && !port_rst[i]) |=> cmpl_active[i]);

      p_adv_needs_active_r9: assert property (@(posedge clk) disable iff (!rst_ni)
        !(cmpl_active[i] && lfps_ping[i]) |=> !pat_adv[i]);

      p_idx_wraps_r10: assert property (@(posedge clk) disable iff (!rst_ni)
        (cmpl_active[i] && lfps_ping[i] && !port_rst[i] &&
         pat_idx[i*PAT_W +: PAT_W] == PAT_W'(N_PAT - 1))
        |=> (pat_idx[i*PAT_W +: PAT_W] == '0));

      p_idx_in_range_r10: assert property (@(posedge clk) disable iff (!rst_ni)
        pat_idx[i*PAT_W +: PAT_W] <= PAT_W'(N_PAT - 1));

      if (i > 0) begin : g_ds
        p_ds_entry_needs_link_r5: assert property (@(posedge clk) disable iff (!rst_ni)
          $rose(cmpl_active[i]) |-> $past(us_link_ok));
      end
    end
  endgenerate

endmodule

bind cmpl_entry_ctrl cmpl_entry_chk #(
  .NP   (NP),
  .N_PAT(N_PAT),
  .PAT_W(PAT_W)
) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .port_rst   (port_rst),
  .lfps_ping  (lfps_ping),
  .us_link_ok (us_link_ok),
  .cmpl_active(cmpl_active),
  .pat_adv    (pat_adv),
  .pat_idx    (pat_idx)
);

// File: tb/tb_cmpl_entry_ctrl.sv
module tb_cmpl_entry_ctrl;
  localparam int N_DS = 3;
  localparam int NP = N_DS + 1;
  localparam int CLK_HZ = 4000;
  localparam int TIMEOUT_MS = 5;
  localparam int N_PAT = 5;
  localparam int PORT_W = $clog2(NP);
  localparam int PAT_W = $clog2(N_PAT);
  localparam int LIM = (CLK_HZ / 1000) * TIMEOUT_MS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [NP-1:0] port_rst, rx_term, poll_active, poll_ok, lfps_ping;
  logic us_link_ok, ds_to_en, ds_cmd_mode, cmd_valid;
  logic [PORT_W-1:0] cmd_port;
  logic [NP-1:0] cmpl_active, pat_adv;
  logic [NP*PAT_W-1:0] pat_idx;

  cmpl_entry_ctrl #(
    .N_DS(N_DS), .CLK_HZ(CLK_HZ), .TIMEOUT_MS(TIMEOUT_MS), .N_PAT(N_PAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .rx_term(rx_term),
    .poll_active(poll_active), .poll_ok(poll_ok), .us_link_ok(us_link_ok),
    .ds_to_en(ds_to_en), .ds_cmd_mode(ds_cmd_mode), .cmd_valid(cmd_valid),
    .cmd_port(cmd_port), .lfps_ping(lfps_ping), .cmpl_active(cmpl_active),
    .pat_adv(pat_adv), .pat_idx(pat_idx)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  int m_cnt [NP];
  int m_idx [NP];
  bit m_never [NP];
  bit m_act [NP];
  bit m_adv [NP];
  int hold = 2;

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_cnt[i] = 0; m_idx[i] = 0; m_never[i] = 1; m_act[i] = 0; m_adv[i] = 0;
    end
  endtask

  task automatic model_edge();
    bit hit, enter, cmdh;
    if (!rst_n) begin
      model_reset(); hold = 2; return;
    end
    if (hold > 0) begin
      hold--; model_reset(); return;
    end
    for (int i = 0; i < NP; i++) begin
      hit  = (m_cnt[i] == LIM);
      cmdh = cmd_valid && (int'(cmd_port) == i);
      if (i == 0) enter = hit && m_never[i];
      else enter = us_link_ok && (ds_cmd_mode ? cmdh : (ds_to_en && hit && m_never[i]));
      m_adv[i] = !port_rst[i] && m_act[i] && lfps_ping[i];
      if (port_rst[i]) m_idx[i] = 0;
      else if (m_act[i] && lfps_ping[i]) m_idx[i] = (m_idx[i] + 1) % N_PAT;
      if (!poll_active[i] || port_rst[i]) m_cnt[i] = 0;
      else if (rx_term[i] && !poll_ok[i] && m_cnt[i] < LIM) m_cnt[i]++;
      m_never[i] = m_never[i] && !poll_ok[i];
      m_act[i] = port_rst[i] ? 1'b0 : (m_act[i] || enter);
    end
  endtask

  task automatic compare();
    logic [NP-1:0] e_act, e_adv;
    logic [NP*PAT_W-1:0] e_idx;
    for (int i = 0; i < NP; i++) begin
      e_act[i] = m_act[i];
      e_adv[i] = m_adv[i];
      e_idx[i*PAT_W +: PAT_W] = PAT_W'(m_idx[i]);
    end
    checks++;
    if (cmpl_active !== e_act || pat_adv !== e_adv || pat_idx !== e_idx) begin
      failures++;
      $display("FAIL %s: act=%b adv=%b idx=%h expected act=%b adv=%b idx=%h",
               tag, cmpl_active, pat_adv, pat_idx, e_act, e_adv, e_idx);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      model_edge();
      @(negedge clk);
      compare();
      port_rst = '0; cmd_valid = 1'b0; lfps_ping = '0;
    end
  endtask

  task automatic check_bit(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: point check got %b expected %b", t, act, exp);
    end
  endtask

  task automatic por();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(3);
  endtask

  bit done = 0;

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; port_rst = '0; rx_term = '0; poll_active = '0; poll_ok = '0;
    lfps_ping = '0; us_link_ok = 1'b0; ds_to_en = 1'b0; ds_cmd_mode = 1'b0;
    cmd_valid = 1'b0; cmd_port = '0;
    model_reset();
    @(negedge clk);
    tag = "R1"; tick(3); rst_n = 1'b1; tick(3);
    check_bit("R1", cmpl_active[0], 1'b0);

    // R2: upstream timeout entry
    tag = "R2"; poll_active[0] = 1'b1; rx_term[0] = 1'b1;
    tick(LIM); check_bit("R2", cmpl_active[0], 1'b0);
    tick(1);   check_bit("R2", cmpl_active[0], 1'b1);
    tick(3);

    // R9, R10: pattern stepping and wrap
    tag = "R9";
    for (int k = 0; k < 3; k++) begin lfps_ping[0] = 1'b1; tick(1); tick(1); end
    lfps_ping[2] = 1'b1; tick(1);
    tag = "R10";
    for (int k = 0; k < 8; k++) begin lfps_ping[0] = 1'b1; tick(1); end
    tick(2);

    // R3: hold and restart on port 1
    tag = "R3"; us_link_ok = 1'b1; ds_to_en = 1'b1;
    poll_active[1] = 1'b1; rx_term[1] = 1'b1; tick(10);
    rx_term[1] = 1'b0; tick(10);
    rx_term[1] = 1'b1; tick(5);
    poll_active[1] = 1'b0; tick(1);
    poll_active[1] = 1'b1; tick(LIM - 5);
    check_bit("R3", cmpl_active[1], 1'b0);
    tag = "R5"; tick(6);
    check_bit("R5", cmpl_active[1], 1'b1);

    // R7: upstream link loss keeps port in compliance
    tag = "R7"; us_link_ok = 1'b0; tick(5);
    check_bit("R7", cmpl_active[1], 1'b1);

    // R8: port reset exits
    tag = "R8"; lfps_ping[1] = 1'b1; tick(1);
    port_rst[1] = 1'b1; lfps_ping[1] = 1'b1; tick(1);
    check_bit("R8", cmpl_active[1], 1'b0);
    poll_active[1] = 1'b0; rx_term[1] = 1'b0; tick(2);

    // R4: polled port blocked, even after port reset
    tag = "R4"; us_link_ok = 1'b1; poll_active[2] = 1'b1;
    poll_ok[2] = 1'b1; tick(1); poll_ok[2] = 1'b0;
    rx_term[2] = 1'b1; tick(LIM + 5);
    port_rst[2] = 1'b1; tick(1); tick(LIM + 5);
    check_bit("R4", cmpl_active[2], 1'b0);

    // R5: enable bit and upstream link gate
    tag = "R5"; ds_to_en = 1'b0; poll_active[3] = 1'b1; rx_term[3] = 1'b1;
    tick(LIM + 5); check_bit("R5", cmpl_active[3], 1'b0);
    ds_to_en = 1'b1; us_link_ok = 1'b0; tick(4);
    check_bit("R5", cmpl_active[3], 1'b0);
    us_link_ok = 1'b1; tick(1); check_bit("R5", cmpl_active[3], 1'b1);

    // R6: command-only entry
    tag = "R6"; por(); ds_cmd_mode = 1'b1; poll_active = '0; rx_term = '0;
    poll_active[1] = 1'b1; rx_term[1] = 1'b1; tick(LIM + 5);
    check_bit("R6", cmpl_active[1], 1'b0);
    cmd_valid = 1'b1; cmd_port = 2'd0; tick(2);
    check_bit("R6", cmpl_active[0], 1'b0);
    us_link_ok = 1'b0; cmd_valid = 1'b1; cmd_port = 2'd2; tick(2);
    check_bit("R6", cmpl_active[2], 1'b0);
    us_link_ok = 1'b1; cmd_valid = 1'b1; cmd_port = 2'd2; tick(1);
    check_bit("R6", cmpl_active[2], 1'b1);

    // R8: port reset wins over simultaneous command
    tag = "R8"; cmd_valid = 1'b1; cmd_port = 2'd3; port_rst[3] = 1'b1; tick(1);
    check_bit("R8", cmpl_active[3], 1'b0);

    // R4: power-on reset lifts the polled block
    tag = "R4"; por(); ds_cmd_mode = 1'b0; ds_to_en = 1'b1; us_link_ok = 1'b1;
    poll_active[2] = 1'b1; rx_term[2] = 1'b1; tick(LIM + 2);
    check_bit("R4", cmpl_active[2], 1'b1);

    // R2: mixed random traffic against the model
    tag = "R2";
    for (int c = 0; c < 600; c++) begin
      rst_n       = (($urandom % 150) != 0);
      port_rst    = (($urandom % 40) == 0) ? NP'($urandom) : '0;
      poll_active = NP'($urandom | $urandom | $urandom);
      rx_term     = NP'($urandom | $urandom);
      poll_ok     = (($urandom % 30) == 0) ? NP'($urandom) : '0;
      lfps_ping   = NP'($urandom);
      us_link_ok  = (($urandom % 4) != 0);
      ds_to_en    = (($urandom % 5) != 0);
      if (($urandom % 60) == 0) ds_cmd_mode = ~ds_cmd_mode;
      cmd_valid   = (($urandom % 10) == 0);
      cmd_port    = PORT_W'($urandom);
      tick(1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule